// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-port synchronous memory. It has one address bus, a read strobe and a write strobe, both active low, and separate input and output data buses. On each rising clock edge the block captures the address and the command. A read returns its word on the output bus one edge after the command edge. The output is registered there and holds its value until the next read delivers a new word.

A write is split over two cycles. The command edge carries only the address. The data word and its active-low byte enables are captured on the edge that follows. The block keeps track of that pending write. A read issued on the data edge of a write to the same address therefore returns the merged word. If both strobes are asserted together, the memory and the output stay unchanged and a one-cycle error flag is raised. A synchronous active-low reset returns the control pipeline to idle and leaves the stored words untouched. A busy flag shows when the block has just been held in reset.

The depth is 2**ADDR_W words of DATA_W bits. A 32K x 32 instance uses ADDR_W=15. The default below is kept small.

Top module: `sram_late_write`

## Requirements
- R1: The array stores 2**ADDR_W words of DATA_W bits. A word written to an address is returned by a later read of that address, and other addresses are not disturbed.
- R2: The command is decoded from (rdN, wrN) at a rising edge: (0,1) is a read, (1,0) is a write, (1,1) is no operation, and (0,0) is illegal.
- R3: A read accepted at edge k puts the addressed word on dataOut right after edge k+1.
- R4: For a write command accepted at edge k, dataIn and wrByteEnN are sampled at edge k+1. Their values at edge k have no effect.
- R5: wrByteEnN has DATA_W/BYTE_W bits, active low. Bit n set to 0 writes bits [BYTE_W*n+BYTE_W-1 : BYTE_W*n]. Bit n set to 1 leaves that byte with its old value.
- R6: A read accepted at edge k+1 of the address written by the command at edge k returns the merged word: new bytes where enabled, old bytes elsewhere.
- R7: An illegal command at edge k sets cmdError to 1 for the cycle after edge k only. It changes neither the memory nor dataOut.
- R8: dataOut changes only in the cycle after a read was accepted. It holds its value after edges that carried a write, a no-op, an illegal command, or no read at all.
- R9: Reset (rstN=0, sampled at the rising edge) forces dataOut to 0, cmdError to 0 and busy to 1, drops any pending write, and ignores the commands at those edges. Stored words are kept. busy is 0 after any edge that samples rstN=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address, captured with the command |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| wrByteEnN | input | DATA_W/BYTE_W | Byte write enables, active low, sampled one cycle after the write command |
| dataIn | input | DATA_W | Write data, sampled one cycle after the write command |
| dataOut | output | DATA_W | Registered read data |
| busy | output | 1 | High in the cycle after an edge that sampled reset |
| cmdError | output | 1 | One-cycle flag after an illegal command |

## Verification
Several behaviours are checked by assertions on every cycle. The error flag must follow an illegal command exactly and never appear without one. dataOut must stay stable unless a read was accepted two edges back. After a reset edge, dataOut must read zero and busy must be set. The bench covers what needs the stored contents: it sweeps every address of a small array, all sixteen byte-enable masks, forwarding from a pending write to an immediate read, and words written before a reset being read back after it. A bench model derived from the requirements gives the expected word for every cycle.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic arrRead;   // capture the array word for a read accepted this edge
    logic commit;    // write the pending word this edge
    logic forward;   // read address matches the pending write
    logic outLoad;   // move the captured word to dataOut
  } ctrlStrobes_t;

endpackage

// File: rtl/sram_lw_ctrl.sv
module sram_lw_ctrl
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  output ctrlStrobes_t      strb,
  output logic [ADDR_W-1:0] commitAddr,
  output logic              busy,
  output logic              cmdError
);

  logic isRead, isWrite, isIllegal;
  logic pendValid, readStage;
  logic [ADDR_W-1:0] pendAddr;

  // Command decode of the two active-low strobes
  always_comb begin
    isRead    = !rdN &&  wrN;
    isWrite   =  rdN && !wrN;
    isIllegal = !rdN && !wrN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b1;
      pendValid <= 1'b0;
      readStage <= 1'b0;
      cmdError  <= 1'b0;
    end else begin
      busy      <= 1'b0;
      pendValid <= isWrite;
      readStage <= isRead;
      cmdError  <= isIllegal;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && isWrite) pendAddr <= addr;
  end

  always_comb begin
    strb.arrRead = rstN && isRead;
    strb.commit  = rstN && pendValid;
    strb.forward = strb.arrRead && strb.commit && (addr == pendAddr);
    strb.outLoad = rstN && readStage;
    commitAddr   = pendAddr;
  end

endmodule

// File: rtl/sram_lw_dpath.sv
module sram_lw_dpath
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-1:0]        commitAddr,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic [DATA_W/BYTE_W-1:0] wrByteEnN,
  output logic [DATA_W-1:0]        dataOut
);

  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] arrWord;

  assign oldWord = mem[commitAddr];

  // Byte merge of the late data into the stored word
  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign mergedWord[b*BYTE_W +: BYTE_W] =
      wrByteEnN[b] ? oldWord[b*BYTE_W +: BYTE_W] : dataIn[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.commit)  mem[commitAddr] <= mergedWord;
    if (strb.arrRead) arrWord <= strb.forward ? mergedWord : mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dataOut <= '0;
    else if (strb.outLoad) dataOut <= arrWord;
  end

endmodule

// File: rtl/sram_late_write.sv
module sram_late_write
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic [DATA_W/BYTE_W-1:0] wrByteEnN,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     busy,
  output logic                     cmdError
);

  ctrlStrobes_t      strb;
  logic [ADDR_W-1:0] commitAddr;

  sram_lw_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .rdN        (rdN),
    .wrN        (wrN),
    .strb       (strb),
    .commitAddr (commitAddr),
    .busy       (busy),
    .cmdError   (cmdError)
  );

  sram_lw_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (addr),
    .commitAddr (commitAddr),
    .dataIn     (dataIn),
    .wrByteEnN  (wrByteEnN),
    .dataOut    (dataOut)
  );

endmodule

// File: rtl/sram_late_write_chk.sv
module sram_late_write_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] dataOut,
  input logic              busy,
  input logic              cmdError
);

  AST_ERR_AFTER_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |=> cmdError);  // R7

  AST_ERR_NEEDS_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> ($past(rstN) && $past(!rdN && !wrN)));  // R7

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && !(!$past(rdN, 2) && $past(wrN, 2)))
      |-> $stable(dataOut));  // R8

  AST_DOUT_ZERO_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (dataOut == '0));  // R9

  AST_BUSY_FROM_RESET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !$past(rstN));  // R9

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> !busy);  // R9

endmodule

bind sram_late_write sram_late_write_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdN      (rdN),
  .wrN      (wrN),
  .dataOut  (dataOut),
  .busy     (busy),
  .cmdError (cmdError)
);

// File: tb/test_sram_late_write.sv
module test_sram_late_write;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BW = 8;
  localparam int NB = DW / BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rdN = 1'b1;
  logic          wrN = 1'b1;
  logic [NB-1:0] wrByteEnN = '1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          busy;
  logic          cmdError;

  sram_late_write #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) i_sram_late_write (
    .clk(clk), .rstN(rstN), .addr(addr), .rdN(rdN), .wrN(wrN),
    .wrByteEnN(wrByteEnN), .dataIn(dataIn), .dataOut(dataOut),
    .busy(busy), .cmdError(cmdError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Requirement model state
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] expDout = '0, expArr = '0;
  logic          expBusy = 1'b1, expErr = 1'b0, pendV = 1'b0, rdStg = 1'b0;
  logic [AW-1:0] pendA = '0;
  logic          rstReq = 1'b0;
  bit            primed = 1'b0;
  string         curReq = "R9";
  int            nChecks = 0, nErrors = 0;

  function automatic logic [DW-1:0] pat(int a, int s);
    logic [DW-1:0] av = DW'(a), sv = DW'(s);
    return (av * 32'h0103_0507) ^ (sv * 32'h9e37_79b9) ^ 32'h5a5a_0000;
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      expBusy = 1'b1; pendV = 1'b0; rdStg = 1'b0; expErr = 1'b0; expDout = '0;
    end else begin
      if (pendV)
        for (int n = 0; n < NB; n++)
          if (!wrByteEnN[n]) mdl[pendA][n*BW +: BW] = dataIn[n*BW +: BW];
      if (rdStg) expDout = expArr;
      if (!rdN && wrN) expArr = mdl[addr];
      expErr  = !rdN && !wrN;
      expBusy = 1'b0;
      pendV   = rdN && !wrN;
      pendA   = addr;
      rdStg   = !rdN && wrN;
    end
  endtask

  // One clock: check outputs of the last edge, drive inputs, take the next edge
  task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [NB-1:0] be);
    @(negedge clk);
    if (primed) begin
      chk(curReq, "dataOut", dataOut, expDout);
      chk("R9", "busy", DW'(busy), DW'(expBusy));
      chk("R7", "cmdError", DW'(cmdError), DW'(expErr));
    end
    rstN = rstReq; rdN = r; wrN = w; addr = a; dataIn = d; wrByteEnN = be;
    @(posedge clk);
    primed = 1'b1;
    modelEdge();
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, AW'(i * 7), pat(i, 99), NB'(i));
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 'x;

    // R9: commands under reset are ignored, busy high, outputs cleared
    curReq = "R9"; rstReq = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, AW'(i), pat(i, 1), '0);
    rstReq = 1'b1;

    // R1, R4: fill every address; data rides on the next command cycle
    curReq = "R1";
    step(1'b1, 1'b0, 0, 32'hdead_beef, '0);
    for (int a = 1; a < DEPTH; a++) step(1'b1, 1'b0, AW'(a), pat(a - 1, 2), '0);
    step(1'b1, 1'b1, 0, pat(DEPTH - 1, 2), '0);
    nop(2);

    // R3: back-to-back reads of all addresses, exact latency
    curReq = "R3";
    for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, AW'(a), pat(a, 77), '0);
    nop(3);

    // R5: every byte-enable mask, then read back
    curReq = "R5";
    for (int m = 0; m < (1 << NB); m++) begin
      step(1'b1, 1'b0, AW'(m), '0, '0);
      step(1'b1, 1'b1, 0, pat(m, 5), NB'(m));
      step(1'b0, 1'b1, AW'(m), '0, '1);
      nop(2);
    end

    // R4: write-phase values at the command edge must not matter
    curReq = "R4";
    step(1'b1, 1'b0, 50, 32'hffff_ffff, '0);
    step(1'b1, 1'b1, 0, pat(50, 6), 4'b1010);
    step(1'b0, 1'b1, 50, '0, '0);
    nop(2);

    // R6: read on the data edge of a write to the same address
    curReq = "R6";
    for (int m = 0; m < (1 << NB); m++) begin
      step(1'b1, 1'b0, AW'(16 + m), '0, '1);
      step(1'b0, 1'b1, AW'(16 + m), pat(m, 7), NB'(m));
      nop(2);
    end
    step(1'b1, 1'b0, 40, '0, '1);
    step(1'b1, 1'b0, 41, pat(40, 8), '0);
    step(1'b0, 1'b1, 41, pat(41, 8), 4'b0101);
    step(1'b0, 1'b1, 40, '0, '1);
    nop(2);

    // R7: illegal commands leave memory and dataOut unchanged
    curReq = "R7";
    step(1'b0, 1'b1, 5, '0, '1);
    step(1'b0, 1'b0, 5, 32'h1234_5678, '0);
    step(1'b0, 1'b0, 6, 32'h8765_4321, '0);
    step(1'b1, 1'b1, 0, 32'h0bad_0bad, '0);
    step(1'b0, 1'b1, 5, '0, '1);
    step(1'b0, 1'b1, 6, '0, '1);
    nop(2);

    // R2: no-op with live data and enables writes nothing
    curReq = "R2";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, AW'(i), 32'hcafe_f00d, '0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, AW'(i), '0, '1);
    nop(2);

    // R8: output holds across idle, writes and illegal cycles
    curReq = "R8";
    step(1'b0, 1'b1, 9, '0, '1);
    step(1'b1, 1'b0, 30, '0, '1);
    step(1'b1, 1'b1, 3, pat(30, 9), '0);
    step(1'b0, 1'b0, 4, '0, '0);
    nop(3);

    // R9: reset drops a pending write and keeps stored words
    curReq = "R9";
    step(1'b1, 1'b0, 60, '0, '1);
    rstReq = 1'b0;
    step(1'b1, 1'b1, 0, 32'h0000_0000, '0);
    step(1'b0, 1'b1, 61, '0, '1);
    step(1'b1, 1'b0, 62, '0, '0);
    rstReq = 1'b1;
    step(1'b0, 1'b1, 60, 32'hffff_ffff, '0);
    step(1'b0, 1'b1, 62, '0, '1);
    step(1'b0, 1'b1, 10, '0, '1);
    nop(3);

    finish();
  end

endmodule